// File: doc/BRIEF.md
# Dispatch Group Former

This block sits between a decoded-instruction queue and the out-of-order back end. Each cycle the queue offers up to eight decoded instructions on parallel lanes, each lane carrying a branch flag, a resource-class tag and a payload. The former packs them, strictly in program order, into five-slot dispatch groups. Slots 0 to 3 take ordinary instructions. Slot 4 is reserved for a single branch. Any slot left unfilled goes out as a no-op, meaning its valid bit is clear.

A finished group leaves as one unit, and only when every resource class its members use is marked available and the group-tracking buffer has a free entry. The buffer holds a fixed number of groups and retires them in order, one per retire pulse. A partial group that has no more input to draw from is held across cycles until it is completed or drained. A flush discards the partial group and empties the tracking buffer.

The queue must present valid lanes contiguously from lane 0. The former reports how many lanes it consumed in a cycle. Lanes it did not consume must be offered again, starting at lane 0, in the following cycle.

Top module: `dispatch_group_former`

## Requirements
- R1: Non-branch instructions fill slots 0,1,2,3 in program order starting at slot 0 with no gaps; slot 4 holds only a branch; `grp_slot_v` bit i marks slot i occupied and a clear bit is a no-op; slot i payload is `grp_slot_data[16*i +: 16]`.
- R2: A group holds at most one branch; a branch closes the group it joins, and lanes after it are not consumed that cycle.
- R3: Once four non-branch instructions are placed, the group closes; if the very next valid lane is a branch it joins slot 4 in the same group, otherwise slot 4 is a no-op.
- R4: An unclosed group is kept across cycles and later input continues filling it; in a cycle with no valid lane (`in_valid[0]` low), a pending partial group is dispatched padded with no-ops.
- R5: `in_take` equals the number of lanes, counted from lane 0, consumed in the current cycle; the lanes beyond it are left for the queue to present again.
- R6: If any occupied slot's class tag indexes a clear bit of `res_avail`, no group is issued, `in_take` is 0 and the partial group is kept unchanged.
- R7: While the tracker holds 20 groups, `in_ready` is low, `in_take` is 0 and no group is issued.
- R8: Group tags count 0,1,...,19 then wrap to 0; each `grp_retire` pulse frees the oldest entry, and a pulse with the tracker empty is ignored.
- R9: A cycle with `flush` high consumes nothing, issues no group, discards the partial group and empties the tracker, so the next tag is 0.
- R10: A group taken at a clock edge appears on the group outputs right after that edge, with `grp_valid` high for exactly that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Synchronous flush of partial group and tracker |
| in_valid | input | 8 | Lane valid bits, contiguous from lane 0 |
| in_branch | input | 8 | Lane is a branch |
| in_cls | input | 16 | Resource-class tag per lane, 2 bits each |
| in_data | input | 128 | Payload per lane, 16 bits each |
| in_ready | output | 1 | Former can accept input this cycle |
| in_take | output | 4 | Number of lanes consumed this cycle |
| res_avail | input | 4 | One availability bit per resource class |
| grp_retire | input | 1 | Retire the oldest tracked group |
| grp_valid | output | 1 | A group is issued this cycle |
| grp_tag | output | 5 | Tracker tag of the issued group |
| grp_slot_v | output | 5 | Slot occupancy, bit 4 is the branch slot |
| grp_slot_cls | output | 10 | Class tag per slot |
| grp_slot_data | output | 80 | Payload per slot |

## Verification
`in_ready` and `in_take` are combinational from the inputs and the registered state. They are therefore due in the same cycle the stimulus is applied, and the bench reads them one nanosecond after it drives the lanes on the falling edge. Group outputs are registered once, so the group due from a stimulus is read at the next falling edge, and one falling edge after that `grp_valid` must be low again. Retire and flush act on the rising edge between those two falling edges. Their effect on `in_ready` and on the next tag is read in the following low phase.

// File: rtl/gf_pkg.sv
package gf_pkg;
  localparam int GF_ALU_SLOTS = 4;
  localparam int GF_SLOTS     = GF_ALU_SLOTS + 1;
  localparam int GF_BR_SLOT   = GF_ALU_SLOTS;
endpackage

// File: rtl/gf_pack.sv
module gf_pack
  import gf_pkg::*;
#(
  parameter int NL  = 8,
  parameter int DW  = 16,
  parameter int CW  = 2,
  localparam int TKW = $clog2(NL + 1)
) (
  input  logic [2:0]                 part_cnt,
  input  logic [GF_ALU_SLOTS*CW-1:0] part_cls,
  input  logic [GF_ALU_SLOTS*DW-1:0] part_data,
  input  logic [NL-1:0]              in_valid,
  input  logic [NL-1:0]              in_branch,
  input  logic [NL*CW-1:0]           in_cls,
  input  logic [NL*DW-1:0]           in_data,
  output logic                       close,
  output logic [TKW-1:0]             take,
  output logic [2:0]                 nb_cnt,
  output logic [GF_SLOTS-1:0]        slot_v,
  output logic [GF_SLOTS*CW-1:0]     slot_cls,
  output logic [GF_SLOTS*DW-1:0]     slot_data
);
  int   nb;
  int   tk;
  logic stop;
  logic brf;

  always_comb begin
    nb        = int'(part_cnt);
    tk        = 0;
    stop      = 1'b0;
    brf       = 1'b0;
    slot_v    = '0;
    slot_cls  = '0;
    slot_data = '0;
    for (int p = 0; p < GF_ALU_SLOTS; p++) begin
      if (p < nb) begin
        slot_v[p]             = 1'b1;
        slot_cls[p*CW +: CW]  = part_cls[p*CW +: CW];
        slot_data[p*DW +: DW] = part_data[p*DW +: DW];
      end
    end
    for (int i = 0; i < NL; i++) begin
      if (!stop) begin
        if (!in_valid[i]) begin
          stop = 1'b1;
        end else if (in_branch[i]) begin
          slot_v[GF_BR_SLOT]             = 1'b1;
          slot_cls[GF_BR_SLOT*CW +: CW]  = in_cls[i*CW +: CW];
          slot_data[GF_BR_SLOT*DW +: DW] = in_data[i*DW +: DW];
          tk   = i + 1;
          brf  = 1'b1;
          stop = 1'b1;
        end else if (nb == GF_ALU_SLOTS) begin
          stop = 1'b1;
        end else begin
          slot_v[nb]             = 1'b1;
          slot_cls[nb*CW +: CW]  = in_cls[i*CW +: CW];
          slot_data[nb*DW +: DW] = in_data[i*DW +: DW];
          nb = nb + 1;
          tk = i + 1;
        end
      end
    end
    close  = brf || (nb == GF_ALU_SLOTS) || (!in_valid[0] && (part_cnt != 3'd0));
    take   = TKW'(tk);
    nb_cnt = 3'(nb);
  end
endmodule

// File: rtl/gf_track.sv
module gf_track #(
  parameter int  DEPTH = 20,
  localparam int TW    = $clog2(DEPTH),
  localparam int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          issue,
  input  logic          retire,
  output logic          full,
  output logic [TW-1:0] tag
);
  logic [CNTW-1:0] count_q, count_d;
  logic [TW-1:0]   tag_q, tag_d;
  logic            ret_ok;
  logic            cnt_en;

  always_comb begin
    ret_ok  = retire && (count_q != '0);
    cnt_en  = flush || issue || ret_ok;
    count_d = count_q;
    tag_d   = tag_q;
    if (flush) begin
      count_d = '0;
      tag_d   = '0;
    end else begin
      count_d = count_q + CNTW'(issue) - CNTW'(ret_ok);
      if (issue) tag_d = (tag_q == TW'(DEPTH - 1)) ? '0 : tag_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      tag_q   <= '0;
    end else if (cnt_en) begin
      count_q <= count_d;
      tag_q   <= tag_d;
    end
  end

  assign full = (count_q == CNTW'(DEPTH));
  assign tag  = tag_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (count_q < CNTW'(DEPTH)));  // R7
  AST_EMPTY_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && (count_q == '0) && !issue && !flush) |=> (count_q == '0));  // R8
endmodule

// File: rtl/dispatch_group_former.sv
module dispatch_group_former
  import gf_pkg::*;
#(
  parameter int  NL    = 8,
  parameter int  DW    = 16,
  parameter int  CW    = 2,
  parameter int  DEPTH = 20,
  localparam int NCLS  = 1 << CW,
  localparam int TW    = $clog2(DEPTH),
  localparam int TKW   = $clog2(NL + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic [NL-1:0]          in_valid,
  input  logic [NL-1:0]          in_branch,
  input  logic [NL*CW-1:0]       in_cls,
  input  logic [NL*DW-1:0]       in_data,
  output logic                   in_ready,
  output logic [TKW-1:0]         in_take,
  input  logic [NCLS-1:0]        res_avail,
  input  logic                   grp_retire,
  output logic                   grp_valid,
  output logic [TW-1:0]          grp_tag,
  output logic [GF_SLOTS-1:0]    grp_slot_v,
  output logic [GF_SLOTS*CW-1:0] grp_slot_cls,
  output logic [GF_SLOTS*DW-1:0] grp_slot_data
);
  logic [1:0] rst_sync;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  logic [2:0]                 part_cnt_q, part_cnt_d;
  logic [GF_ALU_SLOTS*CW-1:0] part_cls_q, part_cls_d;
  logic [GF_ALU_SLOTS*DW-1:0] part_data_q, part_data_d;
  logic                       part_en;

  logic                       close;
  logic [TKW-1:0]             pk_take;
  logic [2:0]                 nb_cnt;
  logic [GF_SLOTS-1:0]        slot_v;
  logic [GF_SLOTS*CW-1:0]     slot_cls;
  logic [GF_SLOTS*DW-1:0]     slot_data;

  logic                       full;
  logic [TW-1:0]              trk_tag;
  logic [NCLS-1:0]            need;
  logic                       res_ok;
  logic                       fire;

  gf_pack #(.NL(NL), .DW(DW), .CW(CW)) u_pack (
    .part_cnt  (part_cnt_q),
    .part_cls  (part_cls_q),
    .part_data (part_data_q),
    .in_valid  (in_valid),
    .in_branch (in_branch),
    .in_cls    (in_cls),
    .in_data   (in_data),
    .close     (close),
    .take      (pk_take),
    .nb_cnt    (nb_cnt),
    .slot_v    (slot_v),
    .slot_cls  (slot_cls),
    .slot_data (slot_data)
  );

  gf_track #(.DEPTH(DEPTH)) u_track (
    .clk    (clk),
    .rst_n  (rst_ns),
    .flush  (flush),
    .issue  (fire),
    .retire (grp_retire),
    .full   (full),
    .tag    (trk_tag)
  );

  always_comb begin
    need = '0;
    for (int s = 0; s < GF_SLOTS; s++) begin
      if (slot_v[s]) need[slot_cls[s*CW +: CW]] = 1'b1;
    end
    res_ok   = ((need & ~res_avail) == '0);
    in_ready = !full && !flush;
    fire     = close && res_ok && in_ready;
    if (!in_ready)  in_take = '0;
    else if (close) in_take = fire ? pk_take : '0;
    else            in_take = pk_take;
  end

  always_comb begin
    part_en     = flush || fire || (!close && in_ready);
    part_cnt_d  = part_cnt_q;
    part_cls_d  = part_cls_q;
    part_data_d = part_data_q;
    if (flush || fire) begin
      part_cnt_d = 3'd0;
    end else if (!close && in_ready) begin
      part_cnt_d  = nb_cnt;
      part_cls_d  = slot_cls[GF_ALU_SLOTS*CW-1:0];
      part_data_d = slot_data[GF_ALU_SLOTS*DW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      part_cnt_q  <= '0;
      part_cls_q  <= '0;
      part_data_q <= '0;
    end else if (part_en) begin
      part_cnt_q  <= part_cnt_d;
      part_cls_q  <= part_cls_d;
      part_data_q <= part_data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      grp_valid  <= 1'b0;
      grp_slot_v <= '0;
    end else begin
      grp_valid  <= fire;
      grp_slot_v <= fire ? slot_v : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      grp_tag       <= '0;
      grp_slot_cls  <= '0;
      grp_slot_data <= '0;
    end else if (fire) begin
      grp_tag       <= trk_tag;
      grp_slot_cls  <= slot_cls;
      grp_slot_data <= slot_data;
    end
  end

  AST_SLOT_PREFIX: assert property (@(posedge clk) disable iff (!rst_ns)
    grp_valid |-> (grp_slot_v[GF_ALU_SLOTS-1:0] inside {4'b0000, 4'b0001, 4'b0011, 4'b0111, 4'b1111}));  // R1
  AST_GROUP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_ns)
    grp_valid |-> (grp_slot_v != '0));  // R1
  AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_ns)
    (close && !res_ok) |-> (in_take == '0));  // R6
  AST_FULL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_ns)
    !in_ready |-> (in_take == '0));  // R7
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_ns)
    flush |=> !grp_valid);  // R9
endmodule

// File: tb/dispatch_group_former_tb.sv
`timescale 1ns/1ps
module dispatch_group_former_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush;
  logic [7:0]  in_valid;
  logic [7:0]  in_branch;
  logic [15:0] in_cls;
  logic [127:0] in_data;
  logic        in_ready;
  logic [3:0]  in_take;
  logic [3:0]  res_avail;
  logic        grp_retire;
  logic        grp_valid;
  logic [4:0]  grp_tag;
  logic [4:0]  grp_slot_v;
  logic [9:0]  grp_slot_cls;
  logic [79:0] grp_slot_data;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  dispatch_group_former u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_branch(in_branch), .in_cls(in_cls), .in_data(in_data),
    .in_ready(in_ready), .in_take(in_take), .res_avail(res_avail),
    .grp_retire(grp_retire), .grp_valid(grp_valid), .grp_tag(grp_tag),
    .grp_slot_v(grp_slot_v), .grp_slot_cls(grp_slot_cls), .grp_slot_data(grp_slot_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_lanes();
    in_valid = '0; in_branch = '0; in_cls = '0; in_data = '0;
  endtask

  task automatic lane(input int i, input bit br, input int cls, input int d);
    in_valid[i] = 1'b1;
    in_branch[i] = br;
    in_cls[i*2 +: 2] = 2'(cls);
    in_data[i*16 +: 16] = 16'(d);
  endtask

  task automatic take_is(input string req, input int exp);
    #1;
    chk(in_take == 4'(exp), req, in_take, exp);
  endtask

  task automatic next();
    @(negedge clk);
  endtask

  task automatic grp_is(input string req, input logic [4:0] v, input int tag,
                        input int d0, input int d1, input int d2, input int d3, input int d4);
    int d[5];
    d = '{d0, d1, d2, d3, d4};
    chk(grp_valid == 1'b1, req, grp_valid, 1);
    chk(grp_slot_v == v, req, grp_slot_v, v);
    chk(grp_tag == 5'(tag), req, grp_tag, tag);
    for (int s = 0; s < 5; s++)
      if (v[s]) chk(grp_slot_data[s*16 +: 16] == 16'(d[s]), req, grp_slot_data[s*16 +: 16], d[s]);
  endtask

  task automatic no_grp(input string req);
    chk(grp_valid == 1'b0, req, grp_valid, 0);
  endtask

  task automatic t_reset();
    chk(grp_valid == 1'b0, "R10 reset", grp_valid, 0);
    chk(in_ready == 1'b1, "R7 reset", in_ready, 1);
    take_is("R5 reset", 0);
  endtask

  task automatic t_full_group();
    clear_lanes();
    for (int i = 0; i < 4; i++) lane(i, 0, 0, 'h11 + i);
    lane(4, 1, 0, 'h15);
    take_is("R3 four plus branch take", 5);
    next(); clear_lanes();
    grp_is("R1 R3 full group", 5'b11111, 0, 'h11, 'h12, 'h13, 'h14, 'h15);
    next();
    no_grp("R10 single cycle group");
  endtask

  task automatic t_branch_close();
    clear_lanes();
    lane(0, 0, 0, 'h21); lane(1, 1, 0, 'h22); lane(2, 0, 0, 'h23);
    take_is("R2 branch closes take", 2);
    next(); clear_lanes(); lane(0, 0, 0, 'h23);
    grp_is("R2 branch group", 5'b10001, 1, 'h21, 0, 0, 0, 'h22);
    take_is("R5 leftover take", 1);
    next(); clear_lanes();
    no_grp("R4 partial held");
    take_is("R4 drain take", 0);
    next();
    grp_is("R4 drained partial", 5'b00001, 2, 'h23, 0, 0, 0, 0);
  endtask

  task automatic t_four_close();
    clear_lanes();
    for (int i = 0; i < 6; i++) lane(i, 0, 0, 'h31 + i);
    take_is("R3 four close take", 4);
    next(); clear_lanes(); lane(0, 0, 0, 'h35); lane(1, 0, 0, 'h36);
    grp_is("R3 no branch group", 5'b01111, 3, 'h31, 'h32, 'h33, 'h34, 0);
    take_is("R5 two lanes", 2);
    next(); clear_lanes();
    lane(0, 0, 0, 'h37); lane(1, 0, 0, 'h38); lane(2, 0, 0, 'h39);
    no_grp("R4 accumulating");
    take_is("R4 top up take", 2);
    next(); clear_lanes(); lane(0, 0, 0, 'h39); lane(1, 1, 0, 'h3A);
    grp_is("R4 merged group", 5'b01111, 4, 'h35, 'h36, 'h37, 'h38, 0);
    take_is("R2 nb then branch", 2);
    next(); clear_lanes();
    grp_is("R1 order", 5'b10001, 5, 'h39, 0, 0, 0, 'h3A);
  endtask

  task automatic t_resource();
    clear_lanes(); lane(0, 0, 2, 'h41);
    take_is("R6 setup take", 1);
    next(); clear_lanes(); lane(0, 1, 0, 'h42); res_avail = 4'b1011;
    take_is("R6 stall take", 0);
    next();
    no_grp("R6 stalled");
    res_avail = 4'b1111;
    take_is("R6 release take", 1);
    next(); clear_lanes();
    grp_is("R6 kept partial", 5'b10001, 6, 'h41, 0, 0, 0, 'h42);
  endtask

  task automatic t_flush();
    clear_lanes(); lane(0, 0, 0, 'h51);
    take_is("R9 setup", 1);
    next(); clear_lanes(); lane(0, 0, 0, 'h52); lane(1, 1, 0, 'h53); flush = 1'b1;
    take_is("R9 flush take", 0);
    chk(in_ready == 1'b0, "R9 flush ready", in_ready, 0);
    next(); flush = 1'b0; clear_lanes();
    no_grp("R9 no group after flush");
    next();
    no_grp("R9 partial discarded");
    lane(0, 1, 0, 'h54);
    take_is("R9 after flush", 1);
    next(); clear_lanes();
    grp_is("R9 tag restarts", 5'b10000, 0, 0, 0, 0, 0, 'h54);
  endtask

  task automatic t_fill();
    flush = 1'b1;
    next(); flush = 1'b0; grp_retire = 1'b1;
    next(); grp_retire = 1'b0;
    for (int g = 0; g < 20; g++) begin
      clear_lanes(); lane(0, 1, 0, 'h100 + g);
      take_is("R7 fill take", 1);
      next();
      grp_is("R8 tag sequence", 5'b10000, g, 0, 0, 0, 0, 'h100 + g);
    end
    clear_lanes(); lane(0, 1, 0, 'h200);
    #1;
    chk(in_ready == 1'b0, "R7 full ready (R8 empty retire ignored)", in_ready, 0);
    take_is("R7 full take", 0);
    next();
    no_grp("R7 no issue when full");
    grp_retire = 1'b1;
    next(); grp_retire = 1'b0;
    #1;
    chk(in_ready == 1'b1, "R8 retire frees", in_ready, 1);
    take_is("R8 take after retire", 1);
    next(); clear_lanes();
    grp_is("R8 tag wraps", 5'b10000, 0, 0, 0, 0, 0, 'h200);
    #1;
    chk(in_ready == 1'b0, "R7 full again", in_ready, 0);
  endtask

  initial begin
    rst_n = 1'b0; flush = 1'b0; grp_retire = 1'b0; res_avail = 4'b1111;
    clear_lanes();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_full_group();
    t_branch_close();
    t_four_close();
    t_resource();
    t_flush();
    t_fill();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule